// File: doc/BRIEF.md
# Bidirectional Timer Counter with Buffered Compare

This block is an up or up/down timer counter of configurable width (8 bits by default). It moves by one step on each system-clock cycle in which the timer-clock enable is high and a non-zero clock source is selected. It reports when the count sits at zero, at the all-ones value, and at the current end of the count sequence. The end of the sequence is either the all-ones value or the active compare value, depending on the mode.

A compare value is written into a holding buffer. It moves to the active compare register at a boundary that depends on the mode. The active value is checked against the count on every tick. Two sticky flags record wrap-around and compare matches, and software clears them by writing ones. A small register port lets software read and write the count, the compare buffer and the flags, and read back the active compare value.

Top module: `tmr_bidir_cmp`

## Requirements
- R1: After reset the count, the compare buffer, the active compare value and both flags are zero, and the direction is upward (`cnt_down` = 0).
- R2: When `clk_sel` is zero or `tick_en` is low, the count holds its value.
- R3: In the upward modes (`mode[1]` = 0), each tick adds one, and a tick at TOP returns the count to zero. TOP is the all-ones value when `mode[0]` = 0 and the active compare value when `mode[0]` = 1.
- R4: `at_bottom` is high exactly when the count is zero, `at_max` exactly when it is all ones, and `at_top` exactly when it equals the TOP in force.
- R5: The overflow flag (bit 0 of address 2) is set by an upward-mode tick taken from all ones, or by an up/down-mode tick that brings the count to zero. It stays set until a write to address 2 with bit 0 high. A set in the same cycle wins over the clear.
- R6: The compare flag (bit 1 of address 2) is set by a tick taken while the count equals the active compare value. It is cleared by writing address 2 with bit 1 high.
- R7: The first tick after a software write to the count sets no compare flag, even when the count equals the active compare value.
- R8: A software write to the count (address 0) wins over `sw_clear` and over a tick in the same cycle. The written value appears in the next cycle.
- R9: `sw_clear` high, with no count write, zeroes the count in the next cycle.
- R10: In mode 0, a write to the compare buffer (address 1) reaches the active value in the next cycle. In the other modes the active value takes the buffer only on the upward tick that wraps from TOP, or on the up/down tick that reaches zero.
- R11: In up/down modes (`mode[1]` = 1), the count rises to TOP, then falls to zero, then rises again. `cnt_down` is 1 after a downward step and 0 after an upward step.
- R12: Register map: address 0 is the count (read/write), address 1 is the compare buffer (read/write), address 2 is the flags (read, write one to clear), and address 3 is the active compare value (read only). `bus_rdata` is combinational on `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer-clock enable, one step per high cycle |
| clk_sel | input | CS_W | Clock-source select, zero stops the counter |
| mode | input | 2 | bit1: up/down, bit0: TOP from compare |
| sw_clear | input | 1 | Forces the count to zero |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data |
| at_bottom | output | 1 | Count is zero |
| at_max | output | 1 | Count is all ones |
| at_top | output | 1 | Count equals TOP |
| cnt_down | output | 1 | Last step was downward |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench builds the block with an 8-bit counter, a 3-bit clock select and double buffering enabled. Because software can load the count, the wrap from 0xFF to zero and the up/down turn at 0xFF take only a few ticks to reach. With buffering on, the bench can see the difference between mode 0, where the compare value takes effect at once, and the modes that defer it to the TOP or zero boundary.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
   localparam logic [ADDR_W-1:0] A_CMPBUF = 2'd1;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd2;
   localparam logic [ADDR_W-1:0] A_CMPACT = 2'd3;
   localparam int unsigned FLAG_OVF = 0;
   localparam int unsigned FLAG_CMP = 1;
   typedef enum logic [1:0] {
      MODE_UP_MAX = 2'b00,
      MODE_UP_CMP = 2'b01,
      MODE_UD_MAX = 2'b10,
      MODE_UD_CMP = 2'b11
   } tmr_mode_e;
endpackage

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             clr,
   input  logic             updown,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] cnt,
   output logic             dn,
   output logic             wrap_top,
   output logic             reach_bot,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] nxt;
   logic             nxt_dn;

   always_comb begin
      nxt       = cnt;
      nxt_dn    = dn;
      wrap_top  = 1'b0;
      reach_bot = 1'b0;
      ovf_evt   = 1'b0;
      if (ld) begin
         nxt = ld_val;
      end else if (clr) begin
         nxt = ZERO;
      end else if (step) begin
         if (!updown) begin
            nxt_dn  = 1'b0;
            ovf_evt = (cnt == MAXV);
            if (cnt == top_val) begin
               nxt      = ZERO;
               wrap_top = 1'b1;
            end else begin
               nxt = cnt + ONE;
            end
         end else if (!dn) begin
            if (cnt >= top_val) begin
               if (cnt != ZERO) begin
                  nxt    = cnt - ONE;
                  nxt_dn = 1'b1;
               end
            end else begin
               nxt = cnt + ONE;
            end
         end else begin
            if (cnt == ZERO) begin
               if (top_val != ZERO) begin
                  nxt    = ONE;
                  nxt_dn = 1'b0;
               end
            end else begin
               nxt = cnt - ONE;
            end
         end
         if (updown && cnt != ZERO && nxt == ZERO) begin
            reach_bot = 1'b1;
            ovf_evt   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= ZERO;
         dn  <= 1'b0;
      end else begin
         cnt <= nxt;
         dn  <= nxt_dn;
      end
   end

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld && !clr) |=> $stable(cnt));
   p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && !clr && !updown && cnt != top_val) |=> (cnt == $past(cnt) + ONE));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld) |=> (cnt == ZERO));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
   parameter int unsigned CNT_W   = 8,
   parameter bit          DBL_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_buf,
   input  logic [CNT_W-1:0] wdata,
   input  logic             immediate,
   input  logic             load_evt,
   input  logic             step,
   input  logic             cnt_ld,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] cmp_act,
   output logic             match_evt
);
   logic supp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_buf <= '0;
      end else if (wr_buf) begin
         cmp_buf <= wdata;
      end
   end

   generate
      if (DBL_BUF) begin : g_dbl
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmp_act <= '0;
            end else if (immediate) begin
               cmp_act <= wr_buf ? wdata : cmp_buf;
            end else if (load_evt) begin
               cmp_act <= cmp_buf;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmp_act <= '0;
            end else if (wr_buf) begin
               cmp_act <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         supp_q <= 1'b0;
      end else if (cnt_ld) begin
         supp_q <= 1'b1;
      end else if (step) begin
         supp_q <= 1'b0;
      end
   end

   assign match_evt = step && !cnt_ld && !supp_q && (cnt == cmp_act);

   p_act_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!immediate && !load_evt && DBL_BUF) |=> $stable(cmp_act));
endmodule

// File: rtl/tmr_bidir_cmp.sv
module tmr_bidir_cmp
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned CS_W    = 3,
   parameter bit          DBL_BUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [CS_W-1:0]   clk_sel,
   input  logic [1:0]        mode,
   input  logic              sw_clear,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              at_bottom,
   output logic              at_max,
   output logic              at_top,
   output logic              cnt_down,
   output logic              ovf_flag,
   output logic              cmp_flag
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (CS_W >= 1) else $error("CS_W must be at least 1");
   end

   logic             step, wr_cnt, wr_buf, wr_flg;
   logic             updown, top_cmp, immediate;
   logic [CNT_W-1:0] cnt, top_val, cmp_buf, cmp_act;
   logic             wrap_top, reach_bot, ovf_evt, match_evt, load_evt;

   assign step      = tick_en && (clk_sel != '0);
   assign wr_cnt    = bus_we && (bus_addr == A_COUNT);
   assign wr_buf    = bus_we && (bus_addr == A_CMPBUF);
   assign wr_flg    = bus_we && (bus_addr == A_FLAGS);
   assign updown    = mode[1];
   assign top_cmp   = mode[0];
   assign immediate = (mode == MODE_UP_MAX);
   assign top_val   = top_cmp ? cmp_act : MAXV;
   assign load_evt  = updown ? reach_bot : wrap_top;

   tmr_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .ld(wr_cnt), .ld_val(bus_wdata),
      .clr(sw_clear), .updown(updown), .top_val(top_val), .cnt(cnt),
      .dn(cnt_down), .wrap_top(wrap_top), .reach_bot(reach_bot), .ovf_evt(ovf_evt)
   );

   tmr_cmp_unit #(.CNT_W(CNT_W), .DBL_BUF(DBL_BUF)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .wdata(bus_wdata),
      .immediate(immediate), .load_evt(load_evt), .step(step), .cnt_ld(wr_cnt),
      .cnt(cnt), .cmp_buf(cmp_buf), .cmp_act(cmp_act), .match_evt(match_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         cmp_flag <= 1'b0;
      end else begin
         if (ovf_evt) ovf_flag <= 1'b1;
         else if (wr_flg && bus_wdata[FLAG_OVF]) ovf_flag <= 1'b0;
         if (match_evt) cmp_flag <= 1'b1;
         else if (wr_flg && bus_wdata[FLAG_CMP]) cmp_flag <= 1'b0;
      end
   end

   assign at_bottom = (cnt == '0);
   assign at_max    = (cnt == MAXV);
   assign at_top    = (cnt == top_val);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_COUNT:  bus_rdata = cnt;
         A_CMPBUF: bus_rdata = cmp_buf;
         A_FLAGS: begin
            bus_rdata[FLAG_OVF] = ovf_flag;
            bus_rdata[FLAG_CMP] = cmp_flag;
         end
         default:  bus_rdata = cmp_act;
      endcase
   end

   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(wr_flg && bus_wdata[FLAG_OVF])) |=> ovf_flag);
   p_cnt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (bus_rdata == $past(bus_wdata) || bus_addr != A_COUNT));
endmodule

// File: tb/sim_tmr_bidir_cmp.sv
module sim_tmr_bidir_cmp;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [2:0] clk_sel = 3'd1;
   logic [1:0] mode = 2'b00;
   logic       sw_clear = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic at_bottom, at_max, at_top, cnt_down, ovf_flag, cmp_flag;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr_bidir_cmp #(.CNT_W(8), .CS_W(3), .DBL_BUF(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel), .mode(mode),
      .sw_clear(sw_clear), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .at_bottom(at_bottom), .at_max(at_max), .at_top(at_top),
      .cnt_down(cnt_down), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_we = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      for (int i = 0; i < n; i++) cyc();
      tick_en = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      rd(2'd0, v); chk("R1 count", v, 0);
      rd(2'd2, v); chk("R1 flags", v, 0);
      rd(2'd3, v); chk("R1 active cmp", v, 0);
      chk("R1 dir", cnt_down, 0);
      chk("R4 bottom", at_bottom, 1);
      chk("R4 max", at_max, 0);
   endtask

   task automatic t_hold();
      int v;
      clk_sel = 3'd0; ticks(3);
      rd(2'd0, v); chk("R2 clk_sel zero", v, 0);
      clk_sel = 3'd5; cyc(); cyc();
      rd(2'd0, v); chk("R2 tick_en low", v, 0);
      clk_sel = 3'd1;
   endtask

   task automatic t_up_wrap();
      int v;
      wr(2'd0, 8'hFD);
      ticks(1); rd(2'd0, v); chk("R3 up step", v, 8'hFE);
      ticks(1); rd(2'd0, v); chk("R3 up to max", v, 8'hFF);
      chk("R4 max", at_max, 1); chk("R4 top", at_top, 1);
      ticks(1); rd(2'd0, v); chk("R3 wrap", v, 0);
      chk("R5 ovf set", ovf_flag, 1);
      chk("R6 no match", cmp_flag, 0);
      wr(2'd2, 8'h00); chk("R5 write zero keeps", ovf_flag, 1);
      wr(2'd2, 8'h01); chk("R5 ovf clear", ovf_flag, 0);
   endtask

   task automatic t_cmp();
      int v;
      wr(2'd1, 8'h05); rd(2'd3, v); chk("R10 immediate load", v, 5);
      rd(2'd1, v); chk("R12 buffer read", v, 5);
      wr(2'd0, 8'h03);
      ticks(2); chk("R6 before match", cmp_flag, 0);
      ticks(1); chk("R6 match", cmp_flag, 1);
      wr(2'd2, 8'h02); chk("R6 clear", cmp_flag, 0);
   endtask

   task automatic t_supp();
      int v;
      wr(2'd0, 8'h05);
      cyc();
      ticks(1); rd(2'd0, v); chk("R7 count moved", v, 6);
      chk("R7 match suppressed", cmp_flag, 0);
   endtask

   task automatic t_prio();
      int v;
      sw_clear = 1'b1; tick_en = 1'b1;
      wr(2'd0, 8'h40);
      sw_clear = 1'b0; tick_en = 1'b0;
      rd(2'd0, v); chk("R8 write wins", v, 8'h40);
      sw_clear = 1'b1; cyc(); sw_clear = 1'b0;
      rd(2'd0, v); chk("R9 clear", v, 0);
   endtask

   task automatic t_ctc();
      int v;
      wr(2'd1, 8'h03);
      mode = 2'b01;
      wr(2'd0, 8'h00);
      ticks(1);
      wr(2'd1, 8'h06);
      rd(2'd3, v); chk("R10 deferred", v, 3);
      ticks(2); rd(2'd0, v); chk("R3 at cmp top", v, 3);
      chk("R4 top on cmp", at_top, 1);
      rd(2'd3, v); chk("R10 still old", v, 3);
      ticks(1); rd(2'd0, v); chk("R3 wrap at cmp top", v, 0);
      rd(2'd3, v); chk("R10 loaded at top", v, 6);
      chk("R5 no ovf below max", ovf_flag, 0);
      ticks(6); rd(2'd0, v); chk("R3 new top", v, 6);
      ticks(1); rd(2'd0, v); chk("R3 wrap new top", v, 0);
      wr(2'd2, 8'h03);
   endtask

   task automatic t_updown();
      int v;
      mode = 2'b10;
      wr(2'd0, 8'hFE);
      ticks(1); rd(2'd0, v); chk("R11 rise", v, 8'hFF); chk("R11 dir up", cnt_down, 0);
      ticks(1); rd(2'd0, v); chk("R11 turn", v, 8'hFE); chk("R11 dir down", cnt_down, 1);
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h09);
      rd(2'd3, v); chk("R10 ud deferred", v, 6);
      ticks(1); rd(2'd0, v); chk("R11 fall", v, 1);
      ticks(1); rd(2'd0, v); chk("R11 bottom", v, 0);
      chk("R5 ovf at bottom", ovf_flag, 1);
      rd(2'd3, v); chk("R10 loaded at bottom", v, 9);
      ticks(1); rd(2'd0, v); chk("R11 rebound", v, 1); chk("R11 dir up again", cnt_down, 0);
      mode = 2'b11;
      wr(2'd0, 8'h07);
      ticks(2); rd(2'd0, v); chk("R11 reach cmp top", v, 9); chk("R4 top", at_top, 1);
      ticks(1); rd(2'd0, v); chk("R11 turn at cmp top", v, 8); chk("R11 down", cnt_down, 1);
   endtask

   initial begin
      fork
         begin
            repeat (3) cyc();
            rst_n = 1'b1;
            cyc();
            t_reset();
            t_hold();
            t_up_wrap();
            t_cmp();
            t_supp();
            t_prio();
            t_ctc();
            t_updown();
            done = 1'b1;
         end
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               checks++; fails++;
               $display("FAIL watchdog actual=running expected=done");
            end
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule